// File: doc/BRIEF.md
# Double-Rate Command Port Decoder for a Statistics Engine

This block is the host-facing front end of a counter-statistics engine. A packet processor drives it over a look-aside port with separate, one-direction read and write data paths and one address bus that carries two addresses per clock. The read address travels in the high phase of the clock and the write address in the low phase. Write data and byte-write strobes come as two beats per clock, one per phase. The block captures both phases and pairs each write enable with the data burst of the following cycle. It splits every address into an operation code (upper bits) and a counter pointer (lower bits). Each clock it hands the counter core at most one decoded read request and one decoded update command.

Read data from the counter core goes back to the host as a two-beat burst on the read data path, with a valid flag. The read and write paths are independent, so a read and an update can both be accepted in every clock.

Top module: `ddr_cmd_port`

## Requirements
- R1: While `rstN` is low, `rdReqValid`, `cmdValid` and `rdDataValid` are 0.
- R2: `rdEn` (active high) and the read address on `addrDdr` are sampled at the rising clock edge that opens cycle k. When `rdEn` was 1, `rdReqValid` is 1 throughout cycle k+1, with `rdReqOpcode` = address bits [ADDR_W-1:ADDR_W-OPC_W] and `rdReqPtr` = the remaining low bits.
- R3: The write address is the value on `addrDdr` at the falling edge inside cycle k, where k is the cycle whose rising edge sampled `wrEn` = 1. The value on the bus at that rising edge has no effect on the command.
- R4: A write accepted in cycle k uses the two data beats of cycle k+1. The beat on `wrDataDdr` at that rising edge forms `cmdOperand[DATA_W-1:0]`, and the beat at the falling edge forms the upper half. `cmdValid` is 1 throughout cycle k+2 and carries the decoded opcode and pointer of the write address.
- R5: `byteWrDdr` is active high, one bit per byte lane. The rising-edge strobes form `cmdByteMask[DATA_W/8-1:0]` and the falling-edge strobes form the upper half. Every operand byte whose mask bit is 0 is 0.
- R6: For a read accepted in cycle k, `coreRdData` is sampled at the rising edge that ends cycle k+1. `rdDataValid` is 1 throughout cycle k+2. `rdDataDdr` drives the low word of the sample during the high phase and the high word during the low phase.
- R7: A read and a write may be accepted in the same cycle and in every consecutive cycle, with no loss or mixing between the two streams.
- R8: A cycle whose rising edge samples `rdEn` = 0 (or `wrEn` = 0) produces no read request and no read data (or no update command) at the latencies above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; both edges used |
| rstN | input | 1 | Asynchronous reset, active low |
| rdEn | input | 1 | Read enable, sampled at rising edge |
| wrEn | input | 1 | Write enable, sampled at rising edge |
| addrDdr | input | ADDR_W | Shared address: read address at rising edge, write address at falling edge |
| wrDataDdr | input | DATA_W | Write data, one beat per edge |
| byteWrDdr | input | DATA_W/8 | Byte-write strobes, one set per edge |
| coreRdData | input | 2*DATA_W | Counter core response to the current read request |
| rdReqValid | output | 1 | Decoded read request present |
| rdReqOpcode | output | OPC_W | Operation code of the read request |
| rdReqPtr | output | ADDR_W-OPC_W | Counter pointer of the read request |
| cmdValid | output | 1 | Decoded update command present |
| cmdOpcode | output | OPC_W | Operation code of the update |
| cmdPtr | output | ADDR_W-OPC_W | Counter pointer of the update |
| cmdOperand | output | 2*DATA_W | Masked two-beat operand |
| cmdByteMask | output | DATA_W/4 | Byte strobes of both beats |
| rdDataDdr | output | DATA_W | Read data, low word in high phase, high word in low phase |
| rdDataValid | output | 1 | Read burst present this cycle |

## Verification
The latency properties assume that `rdEn` and `wrEn` are low while reset is held, and that every input on the shared bus is stable across the edge that samples it. The mask property also assumes the strobes are stable across their capture edge. The bench changes the first-phase inputs shortly after each falling edge and the second-phase inputs shortly after each rising edge, so each value has almost a half cycle of setup. It holds both enables low during reset and in the closing idle cycles, so every pipelined flag drains to a known state.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;

  // Strobes the control half sends to the datapath half each clock.
  typedef struct packed {
    logic loadRdReq;   // read captured at last rising edge: latch request
    logic loadWrPend;  // write captured at last rising edge: latch write address
    logic loadCmd;     // write data burst complete: form update command
    logic loadRdData;  // read request outstanding: sample core response
    logic firstHalf;   // high phase of the current cycle
  } ctrlStrobes_t;

endpackage

// File: rtl/ddr_cmd_ctrl.sv
module ddr_cmd_ctrl
  import ddr_cmd_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rdEn,
  input  logic         wrEn,
  output ctrlStrobes_t strobes,
  output logic         rdReqValid,
  output logic         cmdValid,
  output logic         rdDataValid
);

  logic rdEnQ, wrEnQ, wrPend, rdReqV, cmdV, rdDataV;
  logic posTog, negTog;

  // Enable pipeline, all on the rising edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdEnQ   <= 1'b0;
      wrEnQ   <= 1'b0;
      wrPend  <= 1'b0;
      rdReqV  <= 1'b0;
      cmdV    <= 1'b0;
      rdDataV <= 1'b0;
      posTog  <= 1'b0;
    end else begin
      rdEnQ   <= rdEn;
      wrEnQ   <= wrEn;
      wrPend  <= wrEnQ;
      rdReqV  <= rdEnQ;
      cmdV    <= wrPend;
      rdDataV <= rdReqV;
      posTog  <= ~posTog;
    end
  end

  // Phase tracker: differs from posTog only during the high phase.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) negTog <= 1'b0;
    else       negTog <= posTog;
  end

  always_comb begin
    strobes.loadRdReq  = rdEnQ;
    strobes.loadWrPend = wrEnQ;
    strobes.loadCmd    = wrPend;
    strobes.loadRdData = rdReqV;
    strobes.firstHalf  = posTog ^ negTog;
  end

  assign rdReqValid  = rdReqV;
  assign cmdValid    = cmdV;
  assign rdDataValid = rdDataV;

endmodule

// File: rtl/ddr_cmd_dpath.sv
module ddr_cmd_dpath
  import ddr_cmd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 20,
  parameter int OPC_W  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobes_t              strobes,
  input  logic [ADDR_W-1:0]         addrDdr,
  input  logic [DATA_W-1:0]         wrDataDdr,
  input  logic [DATA_W/8-1:0]       byteWrDdr,
  input  logic [2*DATA_W-1:0]       coreRdData,
  output logic [OPC_W-1:0]          rdReqOpcode,
  output logic [ADDR_W-OPC_W-1:0]   rdReqPtr,
  output logic [OPC_W-1:0]          cmdOpcode,
  output logic [ADDR_W-OPC_W-1:0]   cmdPtr,
  output logic [2*DATA_W-1:0]       cmdOperand,
  output logic [DATA_W/4-1:0]       cmdByteMask,
  output logic [DATA_W-1:0]         rdDataDdr
);

  localparam int BYTES  = DATA_W / 8;
  localparam int LANES  = 2 * BYTES;
  localparam int PTR_W  = ADDR_W - OPC_W;

  // Rising-edge capture: read address, first data beat, first strobes.
  logic [ADDR_W-1:0] rdAddrQ;
  logic [DATA_W-1:0] dataLoQ;
  logic [BYTES-1:0]  bweLoQ;
  // Falling-edge capture: write address, second data beat, second strobes.
  logic [ADDR_W-1:0] wrAddrQ;
  logic [DATA_W-1:0] dataHiQ;
  logic [BYTES-1:0]  bweHiQ;
  // Write address waiting for its data burst.
  logic [ADDR_W-1:0] wrPendAddr;
  // Read response beats.
  logic [DATA_W-1:0] rdBeatLo, rdBeatHi;

  logic [2*DATA_W-1:0] rawOperand, maskedOperand;
  logic [LANES-1:0]    laneEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdAddrQ <= '0;
      dataLoQ <= '0;
      bweLoQ  <= '0;
    end else begin
      rdAddrQ <= addrDdr;
      dataLoQ <= wrDataDdr;
      bweLoQ  <= byteWrDdr;
    end
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAddrQ <= '0;
      dataHiQ <= '0;
      bweHiQ  <= '0;
    end else begin
      wrAddrQ <= addrDdr;
      dataHiQ <= wrDataDdr;
      bweHiQ  <= byteWrDdr;
    end
  end

  assign rawOperand = {dataHiQ, dataLoQ};
  assign laneEn     = {bweHiQ, bweLoQ};

  for (genvar b = 0; b < LANES; b++) begin : gLane
    assign maskedOperand[b*8 +: 8] = laneEn[b] ? rawOperand[b*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdReqOpcode <= '0;
      rdReqPtr    <= '0;
      wrPendAddr  <= '0;
      cmdOpcode   <= '0;
      cmdPtr      <= '0;
      cmdOperand  <= '0;
      cmdByteMask <= '0;
      rdBeatLo    <= '0;
      rdBeatHi    <= '0;
    end else begin
      if (strobes.loadRdReq) begin
        rdReqOpcode <= rdAddrQ[ADDR_W-1 -: OPC_W];
        rdReqPtr    <= rdAddrQ[PTR_W-1:0];
      end
      if (strobes.loadWrPend) begin
        wrPendAddr <= wrAddrQ;
      end
      if (strobes.loadCmd) begin
        cmdOpcode   <= wrPendAddr[ADDR_W-1 -: OPC_W];
        cmdPtr      <= wrPendAddr[PTR_W-1:0];
        cmdOperand  <= maskedOperand;
        cmdByteMask <= laneEn;
      end
      if (strobes.loadRdData) begin
        rdBeatLo <= coreRdData[DATA_W-1:0];
        rdBeatHi <= coreRdData[2*DATA_W-1:DATA_W];
      end
    end
  end

  assign rdDataDdr = strobes.firstHalf ? rdBeatLo : rdBeatHi;

endmodule

// File: rtl/ddr_cmd_port.sv
module ddr_cmd_port
  import ddr_cmd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 20,
  parameter int OPC_W  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     rdEn,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        addrDdr,
  input  logic [DATA_W-1:0]        wrDataDdr,
  input  logic [DATA_W/8-1:0]      byteWrDdr,
  input  logic [2*DATA_W-1:0]      coreRdData,
  output logic                     rdReqValid,
  output logic [OPC_W-1:0]         rdReqOpcode,
  output logic [ADDR_W-OPC_W-1:0]  rdReqPtr,
  output logic                     cmdValid,
  output logic [OPC_W-1:0]         cmdOpcode,
  output logic [ADDR_W-OPC_W-1:0]  cmdPtr,
  output logic [2*DATA_W-1:0]      cmdOperand,
  output logic [DATA_W/4-1:0]      cmdByteMask,
  output logic [DATA_W-1:0]        rdDataDdr,
  output logic                     rdDataValid
);

  ctrlStrobes_t strobes;

  ddr_cmd_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .rdEn        (rdEn),
    .wrEn        (wrEn),
    .strobes     (strobes),
    .rdReqValid  (rdReqValid),
    .cmdValid    (cmdValid),
    .rdDataValid (rdDataValid)
  );

  ddr_cmd_dpath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .OPC_W  (OPC_W)
  ) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .addrDdr     (addrDdr),
    .wrDataDdr   (wrDataDdr),
    .byteWrDdr   (byteWrDdr),
    .coreRdData  (coreRdData),
    .rdReqOpcode (rdReqOpcode),
    .rdReqPtr    (rdReqPtr),
    .cmdOpcode   (cmdOpcode),
    .cmdPtr      (cmdPtr),
    .cmdOperand  (cmdOperand),
    .cmdByteMask (cmdByteMask),
    .rdDataDdr   (rdDataDdr)
  );

endmodule

// File: rtl/ddr_cmd_port_chk.sv
module ddr_cmd_port_chk #(
  parameter int DATA_W = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 rdEn,
  input logic                 wrEn,
  input logic                 rdReqValid,
  input logic                 cmdValid,
  input logic                 rdDataValid,
  input logic [2*DATA_W-1:0]  cmdOperand,
  input logic [DATA_W/4-1:0]  cmdByteMask
);

  localparam int LANES = DATA_W / 4;

  logic [1:0] warmCnt;
  logic       warm;
  logic [2*DATA_W-1:0] laneBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               warmCnt <= 2'd0;
    else if (warmCnt != 2'd3) warmCnt <= warmCnt + 2'd1;
  end
  assign warm = (warmCnt == 2'd3);

  for (genvar b = 0; b < LANES; b++) begin : gBits
    assign laneBits[b*8 +: 8] = {8{cmdByteMask[b]}};
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |-> (!rdReqValid && !cmdValid && !rdDataValid)); // R1

  AST_RD_REQ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    warm |-> (rdReqValid == $past(rdEn, 2))); // R2

  AST_CMD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    warm |-> (cmdValid == $past(wrEn, 3))); // R4

  AST_RD_DATA_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    warm |-> (rdDataValid == $past(rdEn, 3))); // R6

  AST_MASKED_LANES_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> ((cmdOperand & ~laneBits) == '0)); // R5

endmodule

bind ddr_cmd_port ddr_cmd_port_chk #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .rdEn        (rdEn),
  .wrEn        (wrEn),
  .rdReqValid  (rdReqValid),
  .cmdValid    (cmdValid),
  .rdDataValid (rdDataValid),
  .cmdOperand  (cmdOperand),
  .cmdByteMask (cmdByteMask)
);

// File: tb/ddr_cmd_port_tb.sv
module ddr_cmd_port_tb_top;

  localparam int DW = 32;
  localparam int AW = 20;
  localparam int OW = 4;
  localparam int PW = AW - OW;
  localparam int NC = 260;

  logic clk = 1'b0;
  logic rstN;
  logic rdEn, wrEn;
  logic [AW-1:0]   addrDdr;
  logic [DW-1:0]   wrDataDdr;
  logic [DW/8-1:0] byteWrDdr;
  logic [2*DW-1:0] coreRdData;
  logic            rdReqValid, cmdValid, rdDataValid;
  logic [OW-1:0]   rdReqOpcode, cmdOpcode;
  logic [PW-1:0]   rdReqPtr, cmdPtr;
  logic [2*DW-1:0] cmdOperand;
  logic [DW/4-1:0] cmdByteMask;
  logic [DW-1:0]   rdDataDdr;

  always #5 clk = ~clk;

  ddr_cmd_port dut_i (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .addrDdr(addrDdr),
    .wrDataDdr(wrDataDdr), .byteWrDdr(byteWrDdr), .coreRdData(coreRdData),
    .rdReqValid(rdReqValid), .rdReqOpcode(rdReqOpcode), .rdReqPtr(rdReqPtr),
    .cmdValid(cmdValid), .cmdOpcode(cmdOpcode), .cmdPtr(cmdPtr),
    .cmdOperand(cmdOperand), .cmdByteMask(cmdByteMask),
    .rdDataDdr(rdDataDdr), .rdDataValid(rdDataValid)
  );

  function automatic logic [2*DW-1:0] coreModel(logic [OW-1:0] opc, logic [PW-1:0] ptr);
    return {~ptr, opc, 12'h3C3, ptr, 12'h5A5, opc};
  endfunction

  function automatic logic [2*DW-1:0] maskOp(logic [DW-1:0] lo, logic [DW-1:0] hi,
                                             logic [DW/8-1:0] bl, logic [DW/8-1:0] bh);
    logic [2*DW-1:0] raw = {hi, lo};
    logic [DW/4-1:0] m   = {bh, bl};
    logic [2*DW-1:0] res = '0;
    for (int b = 0; b < DW/4; b++) if (m[b]) res[b*8 +: 8] = raw[b*8 +: 8];
    return res;
  endfunction

  // Counter core model: answers the current read request.
  assign coreRdData = coreModel(rdReqOpcode, rdReqPtr);

  logic            rdEnS [NC];
  logic            wrEnS [NC];
  logic [AW-1:0]   rdAS  [NC];
  logic [AW-1:0]   wrAS  [NC];
  logic [DW-1:0]   d0S   [NC];
  logic [DW-1:0]   d1S   [NC];
  logic [DW/8-1:0] b0S   [NC];
  logic [DW/8-1:0] b1S   [NC];

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [2*DW-1:0] act, input logic [2*DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic driveFirst(input int k);
    if (k < NC) begin
      rdEn = rdEnS[k]; wrEn = wrEnS[k]; addrDdr = rdAS[k];
      wrDataDdr = d0S[k]; byteWrDdr = b0S[k];
    end else begin
      rdEn = 1'b0; wrEn = 1'b0; addrDdr = '0; wrDataDdr = '0; byteWrDdr = '0;
    end
  endtask

  task automatic driveSecond(input int k);
    addrDdr = wrAS[k]; wrDataDdr = d1S[k]; byteWrDdr = b1S[k];
  endtask

  task automatic checkFirst(input int k);
    bit expRd  = (k >= 1) && rdEnS[k-1];
    bit expCmd = (k >= 2) && wrEnS[k-2];
    bit expRdD = (k >= 2) && rdEnS[k-2];
    bit busy   = (k >= 2) && rdEnS[k-1] && rdEnS[k-2] && wrEnS[k-2] && wrEnS[k-1];
    check(rdReqValid == expRd, expRd ? "R2" : "R8", "rdReqValid", 64'(rdReqValid), 64'(expRd));
    if (expRd) begin
      check(rdReqOpcode == rdAS[k-1][AW-1 -: OW], busy ? "R7/R2" : "R2", "rdReqOpcode",
            64'(rdReqOpcode), 64'(rdAS[k-1][AW-1 -: OW]));
      check(rdReqPtr == rdAS[k-1][PW-1:0], "R2", "rdReqPtr",
            64'(rdReqPtr), 64'(rdAS[k-1][PW-1:0]));
    end
    check(cmdValid == expCmd, expCmd ? "R4" : "R8", "cmdValid", 64'(cmdValid), 64'(expCmd));
    if (expCmd) begin
      logic [2*DW-1:0] eOp = maskOp(d0S[k-1], d1S[k-1], b0S[k-1], b1S[k-1]);
      check(cmdOpcode == wrAS[k-2][AW-1 -: OW], "R3", "cmdOpcode",
            64'(cmdOpcode), 64'(wrAS[k-2][AW-1 -: OW]));
      check(cmdPtr == wrAS[k-2][PW-1:0], busy ? "R7/R3" : "R3", "cmdPtr",
            64'(cmdPtr), 64'(wrAS[k-2][PW-1:0]));
      check(cmdOperand == eOp, "R4", "cmdOperand", cmdOperand, eOp);
      check(cmdByteMask == {b1S[k-1], b0S[k-1]}, "R5", "cmdByteMask",
            64'(cmdByteMask), 64'({b1S[k-1], b0S[k-1]}));
    end
    check(rdDataValid == expRdD, expRdD ? "R6" : "R8", "rdDataValid hi phase",
          64'(rdDataValid), 64'(expRdD));
    if (expRdD) begin
      logic [2*DW-1:0] eRd = coreModel(rdAS[k-2][AW-1 -: OW], rdAS[k-2][PW-1:0]);
      check(rdDataDdr == eRd[DW-1:0], busy ? "R7/R6" : "R6", "rdData beat0",
            64'(rdDataDdr), 64'(eRd[DW-1:0]));
    end
  endtask

  task automatic checkSecond(input int k);
    bit expRdD = (k >= 2) && rdEnS[k-2];
    check(rdDataValid == expRdD, expRdD ? "R6" : "R8", "rdDataValid lo phase",
          64'(rdDataValid), 64'(expRdD));
    if (expRdD) begin
      logic [2*DW-1:0] eRd = coreModel(rdAS[k-2][AW-1 -: OW], rdAS[k-2][PW-1:0]);
      check(rdDataDdr == eRd[2*DW-1:DW], "R6", "rdData beat1",
            64'(rdDataDdr), 64'(eRd[2*DW-1:DW]));
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < NC; k++) begin
      rdEnS[k] = ($urandom_range(3) != 0);
      wrEnS[k] = ($urandom_range(3) != 0);
      rdAS[k]  = AW'($urandom);
      wrAS[k]  = AW'($urandom);
      d0S[k]   = $urandom;
      d1S[k]   = $urandom;
      b0S[k]   = 4'($urandom);
      b1S[k]   = 4'($urandom);
      if (k >= NC - 4) begin rdEnS[k] = 1'b0; wrEnS[k] = 1'b0; end
    end
    // Directed corners: idle, all lanes on, all lanes off, extreme opcodes,
    // then a back-to-back read+write run.
    rdEnS[0] = 1'b0; wrEnS[0] = 1'b0;
    rdEnS[1] = 1'b1; wrEnS[1] = 1'b1; rdAS[1] = 20'hFFFFF; wrAS[1] = 20'h00000;
    b0S[2] = 4'hF; b1S[2] = 4'hF; d0S[2] = 32'hDEADBEEF; d1S[2] = 32'hCAFEF00D;
    rdEnS[2] = 1'b0; wrEnS[2] = 1'b1; wrAS[2] = 20'hF0001;
    b0S[3] = 4'h0; b1S[3] = 4'h0; d0S[3] = 32'hFFFFFFFF; d1S[3] = 32'hFFFFFFFF;
    rdEnS[3] = 1'b0; wrEnS[3] = 1'b0;
    for (int k = 4; k < 12; k++) begin rdEnS[k] = 1'b1; wrEnS[k] = 1'b1; end
    rdAS[5] = 20'h0ABCD; wrAS[5] = 20'hF5432;

    rstN = 1'b0;
    driveFirst(NC);
    repeat (3) @(posedge clk);
    #2;
    check(!rdReqValid && !cmdValid && !rdDataValid, "R1", "valids in reset",
          64'({rdReqValid, cmdValid, rdDataValid}), 64'(0));
    @(negedge clk);
    #2;
    rstN = 1'b1;
    check(!rdReqValid && !cmdValid && !rdDataValid, "R1", "valids after reset",
          64'({rdReqValid, cmdValid, rdDataValid}), 64'(0));
    driveFirst(0);
    for (int k = 0; k < NC; k++) begin
      @(posedge clk);
      #2;
      checkFirst(k);
      driveSecond(k);
      @(negedge clk);
      #2;
      checkSecond(k);
      driveFirst(k + 1);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (NC + 2000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule